// File: doc/BRIEF.md
# Multicore Global Configuration Register Block

This block is a memory-mapped register file shared by a group of processor cores. Every bus request carries the index of the core that issued it. The address space is split into three windows. The global window holds registers common to the whole cluster. The own-core window reaches the requesting core's private registers. The remote-core window reaches the private registers of whichever core the requester has chosen through its own selector register. Both per-core windows use the same register offsets.

The block drives a 64-bit boot vector per core, which follows that core's stored reset base. It also drives a shifted copy of its own relocatable base to all cores. Two attached peripheral regions, an interrupt controller and a power controller, each get a base-address output and an enable output. Each region has a presence input that gates writes to its base register and is reported in a status register. Reads return data one cycle after the request. Writes take effect at the clock edge that accepts them.

Window map (address bits [15:13]): 0 is global, 1 is own-core, 2 is remote-core, and any other value is unmapped. Inside a window only 8-byte-aligned offsets below 0x40 are decoded. Global offsets: 0x00 cluster config, 0x08 self base, 0x10 revision, 0x18 interrupt-region base, 0x20 power-region base, 0x28 interrupt-region status, 0x30 power-region status, 0x38 cache config. Per-core offsets: 0x00 core config, 0x08 selector, 0x10 reset base.

Top module: `mc_cfg_regs`

## Requirements
- R1: After reset, every core's reset base reads 0xBFC00000, every boot vector is 0xFFFFFFFF_BFC00000, every selector reads 0, both region bases read 0 with enables low, and the self-base output equals the self-base reset parameter shifted right by 4.
- R2: A read request produces `rsp_valid` high with its data exactly one cycle later. `rsp_valid` is low in every cycle that does not follow a read request.
- R3: An own-core window access (bits [15:13]=1) reads or writes the registers of the requesting core only.
- R4: A remote-core window access (bits [15:13]=2) reads or writes the registers of the core named by the requester's selector.
- R5: A selector write uses data bits [7:0]. It is applied only when that value is below the core count. Otherwise the old value is kept.
- R6: A reset-base write stores data bits [31:12] (lower bits zero). From the next cycle, the owning core's boot vector is that value sign-extended from bit 31 to 64 bits.
- R7: The core config register reads core count minus 1 through both per-core windows.
- R8: The cluster config register reads 0. The revision register reads the revision parameter (default 0x800). The cache config register reads only bit 20 (bypass) set.
- R9: A region base register keeps the enable flag in bit 0 and the base field in bits [31:15]. It reads back the masked value, and the region's base output and enable output follow it.
- R10: A write to a region base register while that region's presence input is low leaves the register and its outputs unchanged.
- R11: A region status register reads 1 when its presence input is high and 0 otherwise.
- R12: The self-base register stores data bits [47:15]. `self_base_sh_o` is the stored value shifted right by 4.
- R13: A read of an unmapped offset or window returns 0. A write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_core | input | SEL_W | Index of the requesting core |
| req_addr | input | ADDR_W | Byte address inside the block |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 64 | Read data |
| ictl_present | input | 1 | Interrupt-controller region is attached |
| pwr_present | input | 1 | Power-controller region is attached |
| ictl_base_o | output | 32 | Interrupt-controller region base address |
| ictl_en_o | output | 1 | Interrupt-controller region enable |
| pwr_base_o | output | 32 | Power-controller region base address |
| pwr_en_o | output | 1 | Power-controller region enable |
| self_base_sh_o | output | 64 | Self base shifted right by 4, shared by all cores |
| core_vector_o | output | NUM_CORES*64 | Boot vector per core, core 0 in the low 64 bits |

## Verification
The per-core registers are accessed by several different requesters through both windows, with the selectors set to point at other cores. This shows whether the remote window follows the requester's own selector rather than the target's selector or the raw core index. Selector writes are tried with values just in range, exactly at the core count, and far above it, which separates a correct bound check from one that is off by one or truncates. Region writes are made with presence high and with presence low, and with data that has bits outside the field masks set, which exposes faults in the gating and the masks. Reads of unmapped offsets and of an unmapped window, made after writes to them, show that stray accesses change nothing.

// File: rtl/mc_cfg_pkg.sv
package mc_cfg_pkg;

   typedef enum logic [1:0] {
      WIN_NONE  = 2'd0,
      WIN_GLOB  = 2'd1,
      WIN_OWN   = 2'd2,
      WIN_REMOTE = 2'd3
   } win_e;

   typedef enum logic [3:0] {
      RG_NONE,
      RG_CLUSTER_CFG,
      RG_SELF_BASE,
      RG_REVISION,
      RG_ICTL_BASE,
      RG_PWR_BASE,
      RG_ICTL_STAT,
      RG_PWR_STAT,
      RG_CACHE_CFG,
      RG_CORE_CFG,
      RG_SELECTOR,
      RG_RESET_BASE
   } reg_id_e;

   // word index (offset / 8) inside a window
   localparam int unsigned W_CLUSTER_CFG = 0;
   localparam int unsigned W_SELF_BASE   = 1;
   localparam int unsigned W_REVISION    = 2;
   localparam int unsigned W_ICTL_BASE   = 3;
   localparam int unsigned W_PWR_BASE    = 4;
   localparam int unsigned W_ICTL_STAT   = 5;
   localparam int unsigned W_PWR_STAT    = 6;
   localparam int unsigned W_CACHE_CFG   = 7;
   localparam int unsigned W_CORE_CFG    = 0;
   localparam int unsigned W_SELECTOR    = 1;
   localparam int unsigned W_RESET_BASE  = 2;

   localparam int unsigned CACHE_BYPASS_BIT = 20;
   localparam logic [31:0] REGION_MASK      = 32'hFFFF_8001;
   localparam logic [31:0] RESET_BASE_MASK  = 32'hFFFF_F000;
   localparam int unsigned SEL_FIELD_W      = 8;

   function automatic int unsigned sel_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/mc_cfg_decode.sv
module mc_cfg_decode
   import mc_cfg_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned WIN_LSB = 13,
   parameter int unsigned NUM_WORDS = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output win_e              win,
   output reg_id_e           rid
);
   localparam int unsigned WSEL_W = ADDR_W - WIN_LSB;
   localparam int unsigned WORD_W = $clog2(NUM_WORDS);

   generate
      if (WIN_LSB < WORD_W + 3 || WSEL_W < 2) begin : g_bad_geom
         $error("mc_cfg_decode: window geometry too small");
      end
   endgenerate

   logic [WSEL_W-1:0]      win_field;
   logic [WIN_LSB-1:0]     offs;
   logic                   offs_ok;
   logic [WORD_W-1:0]      word;

   always_comb begin
      win_field = addr[ADDR_W-1:WIN_LSB];
      offs      = addr[WIN_LSB-1:0];
      offs_ok   = (offs[2:0] == 3'b000) &&
                  ((offs >> 3) < WIN_LSB'(NUM_WORDS));
      word      = offs[WORD_W+2:3];
   end

   always_comb begin
      win = WIN_NONE;
      if (offs_ok) begin
         case (win_field)
            WSEL_W'(0): win = WIN_GLOB;
            WSEL_W'(1): win = WIN_OWN;
            WSEL_W'(2): win = WIN_REMOTE;
            default:    win = WIN_NONE;
         endcase
      end
   end

   always_comb begin
      rid = RG_NONE;
      if (win == WIN_GLOB) begin
         case (int'(word))
            W_CLUSTER_CFG: rid = RG_CLUSTER_CFG;
            W_SELF_BASE:   rid = RG_SELF_BASE;
            W_REVISION:    rid = RG_REVISION;
            W_ICTL_BASE:   rid = RG_ICTL_BASE;
            W_PWR_BASE:    rid = RG_PWR_BASE;
            W_ICTL_STAT:   rid = RG_ICTL_STAT;
            W_PWR_STAT:    rid = RG_PWR_STAT;
            W_CACHE_CFG:   rid = RG_CACHE_CFG;
            default:       rid = RG_NONE;
         endcase
      end else if (win == WIN_OWN || win == WIN_REMOTE) begin
         case (int'(word))
            W_CORE_CFG:   rid = RG_CORE_CFG;
            W_SELECTOR:   rid = RG_SELECTOR;
            W_RESET_BASE: rid = RG_RESET_BASE;
            default:      rid = RG_NONE;
         endcase
      end
   end

   // R13: no register is selected outside a decoded window
   always_comb begin
      a_r13_none_outside: assert (win != WIN_NONE || rid == RG_NONE);
   end

endmodule

// File: rtl/mc_cfg_core_slot.sv
module mc_cfg_core_slot
   import mc_cfg_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4,
   parameter logic [31:0] RB_INIT   = 32'hBFC0_0000,
   localparam int unsigned SEL_W    = sel_width(NUM_CORES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_we,
   input  logic             rb_we,
   input  logic [31:0]      wdata,
   output logic [SEL_W-1:0] sel_q,
   output logic [31:0]      rb_q,
   output logic [63:0]      vec_o
);
   localparam logic [31:0] RB_RESET = RB_INIT & RESET_BASE_MASK;

   logic [SEL_FIELD_W-1:0] sel_field;
   logic                   sel_ok;

   always_comb begin
      sel_field = wdata[SEL_FIELD_W-1:0];
      sel_ok    = (int'(sel_field) < int'(NUM_CORES));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (sel_we && sel_ok) begin
         sel_q <= sel_field[SEL_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rb_q <= RB_RESET;
      end else if (rb_we) begin
         rb_q <= wdata & RESET_BASE_MASK;
      end
   end

   assign vec_o = {{32{rb_q[31]}}, rb_q};

   // R5: the selector never names a missing core
   a_r5_sel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(sel_q) < int'(NUM_CORES));
   // R5: an out-of-range selector write leaves the selector unchanged
   a_r5_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_we && int'(wdata[SEL_FIELD_W-1:0]) >= int'(NUM_CORES)) |=> $stable(sel_q));
   // R6: a reset-base write shows up on the vector in the next cycle
   a_r6_vector_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rb_we |=> (vec_o[31:12] == $past(wdata[31:12])) && (vec_o[11:0] == 12'h0)
                && (vec_o[63:32] == {32{$past(wdata[31])}}));

endmodule

// File: rtl/mc_cfg_region.sv
module mc_cfg_region
   import mc_cfg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        present,
   input  logic        we,
   input  logic [31:0] wdata,
   output logic [31:0] reg_q,
   output logic [31:0] base_o,
   output logic        en_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_q <= '0;
      end else if (we && present) begin
         reg_q <= wdata & REGION_MASK;
      end
   end

   assign base_o = {reg_q[31:1], 1'b0};
   assign en_o   = reg_q[0];

   // R10: an absent region ignores writes
   a_r10_absent_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !present) |=> ($stable(base_o) && $stable(en_o)));
   // R9: an accepted write drives the enable from data bit 0
   a_r9_enable_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (we && present) |=> (en_o == $past(wdata[0])));
   // R9: the base output carries no bits outside the field
   a_r9_base_field: assert property (@(posedge clk) disable iff (!rst_n)
      base_o[14:0] == 15'h0);

endmodule

// File: rtl/mc_cfg_regs.sv
module mc_cfg_regs
   import mc_cfg_pkg::*;
#(
   parameter int unsigned NUM_CORES     = 4,
   parameter int unsigned ADDR_W        = 16,
   parameter int unsigned WIN_LSB       = 13,
   parameter logic [31:0] REVISION      = 32'h0000_0800,
   parameter logic [63:0] SELF_MASK     = 64'h0000_FFFF_FFFF_8000,
   parameter logic [63:0] SELF_INIT     = 64'h0000_0000_1FBF_8000,
   parameter logic [31:0] RB_INIT       = 32'hBFC0_0000,
   localparam int unsigned SEL_W        = sel_width(NUM_CORES),
   localparam int unsigned VEC_W        = NUM_CORES * 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [SEL_W-1:0]  req_core,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [63:0]       req_wdata,
   output logic              rsp_valid,
   output logic [63:0]       rsp_rdata,
   input  logic              ictl_present,
   input  logic              pwr_present,
   output logic [31:0]       ictl_base_o,
   output logic              ictl_en_o,
   output logic [31:0]       pwr_base_o,
   output logic              pwr_en_o,
   output logic [63:0]       self_base_sh_o,
   output logic [VEC_W-1:0]  core_vector_o
);
   generate
      if (NUM_CORES < 1 || NUM_CORES > 256) begin : g_bad_cores
         $error("mc_cfg_regs: NUM_CORES must be 1..256");
      end
      if ((SELF_INIT & ~SELF_MASK) != 64'h0) begin : g_bad_self
         $error("mc_cfg_regs: SELF_INIT has bits outside SELF_MASK");
      end
   endgenerate

   // ---------------- decode ----------------
   win_e    win;
   reg_id_e rid;

   mc_cfg_decode #(
      .ADDR_W   (ADDR_W),
      .WIN_LSB  (WIN_LSB),
      .NUM_WORDS(8)
   ) u_decode (
      .addr(req_addr),
      .win (win),
      .rid (rid)
   );

   // ---------------- per-core state ----------------
   logic [SEL_W-1:0] sel_arr [NUM_CORES];
   logic [31:0]      rb_arr  [NUM_CORES];
   logic             core_ok;
   logic             per_core;
   logic [SEL_W-1:0] tgt;
   logic             tgt_ok;
   logic             wr_fire;

   always_comb begin
      core_ok  = (int'(req_core) < int'(NUM_CORES));
      per_core = (win == WIN_OWN) || (win == WIN_REMOTE);
      tgt      = req_core;
      if (core_ok && win == WIN_REMOTE) begin
         tgt = sel_arr[req_core];
      end
      tgt_ok   = core_ok && (int'(tgt) < int'(NUM_CORES));
      wr_fire  = req_valid && req_write && core_ok && (rid != RG_NONE);
   end

   for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
      logic sel_we;
      logic rb_we;
      logic [63:0] vec;

      always_comb begin
         sel_we = wr_fire && per_core && tgt_ok && (int'(tgt) == i) &&
                  (rid == RG_SELECTOR);
         rb_we  = wr_fire && per_core && tgt_ok && (int'(tgt) == i) &&
                  (rid == RG_RESET_BASE);
      end

      mc_cfg_core_slot #(
         .NUM_CORES(NUM_CORES),
         .RB_INIT  (RB_INIT)
      ) u_slot (
         .clk   (clk),
         .rst_n (rst_n),
         .sel_we(sel_we),
         .rb_we (rb_we),
         .wdata (req_wdata[31:0]),
         .sel_q (sel_arr[i]),
         .rb_q  (rb_arr[i]),
         .vec_o (vec)
      );

      assign core_vector_o[i*64 +: 64] = vec;
   end

   // ---------------- peripheral regions ----------------
   logic [31:0] ictl_q;
   logic [31:0] pwr_q;

   mc_cfg_region u_ictl (
      .clk    (clk),
      .rst_n  (rst_n),
      .present(ictl_present),
      .we     (wr_fire && rid == RG_ICTL_BASE),
      .wdata  (req_wdata[31:0]),
      .reg_q  (ictl_q),
      .base_o (ictl_base_o),
      .en_o   (ictl_en_o)
   );

   mc_cfg_region u_pwr (
      .clk    (clk),
      .rst_n  (rst_n),
      .present(pwr_present),
      .we     (wr_fire && rid == RG_PWR_BASE),
      .wdata  (req_wdata[31:0]),
      .reg_q  (pwr_q),
      .base_o (pwr_base_o),
      .en_o   (pwr_en_o)
   );

   // ---------------- self base ----------------
   logic [63:0] self_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         self_q <= SELF_INIT;
      end else if (wr_fire && rid == RG_SELF_BASE) begin
         self_q <= req_wdata & SELF_MASK;
      end
   end

   assign self_base_sh_o = self_q >> 4;

   // ---------------- read path ----------------
   logic [63:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (core_ok) begin
         case (rid)
            RG_CLUSTER_CFG: rd_mux = '0;
            RG_SELF_BASE:   rd_mux = self_q;
            RG_REVISION:    rd_mux = {32'h0, REVISION};
            RG_ICTL_BASE:   rd_mux = {32'h0, ictl_q};
            RG_PWR_BASE:    rd_mux = {32'h0, pwr_q};
            RG_ICTL_STAT:   rd_mux = {63'h0, ictl_present};
            RG_PWR_STAT:    rd_mux = {63'h0, pwr_present};
            RG_CACHE_CFG:   rd_mux = 64'(1) << CACHE_BYPASS_BIT;
            RG_CORE_CFG:    rd_mux = 64'(NUM_CORES - 1);
            RG_SELECTOR:    rd_mux = tgt_ok ? 64'(sel_arr[tgt]) : '0;
            RG_RESET_BASE:  rd_mux = tgt_ok ? {32'h0, rb_arr[tgt]} : '0;
            default:        rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid && !req_write;
         rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
      end
   end

   // R2: each read is answered in the following cycle
   a_r2_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid);
   // R2: no response without a read
   a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rsp_valid);
   // R13: unmapped reads return zero
   a_r13_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && rid == RG_NONE) |=> (rsp_rdata == 64'h0));
   // R12: the shared base copy changes only on a self-base write
   a_r12_self_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_fire && rid == RG_SELF_BASE) |=> $stable(self_base_sh_o));

endmodule

// File: tb/mc_cfg_regs_test.sv
module mc_cfg_regs_test;

   localparam int unsigned NC = 4;

   typedef struct packed {
      logic        wr;
      logic [1:0]  core;
      logic [15:0] addr;
      logic [63:0] data;
      logic [63:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int unsigned NV = 29;
   localparam vec_t TBL [0:NV-1] = '{
      '{1'b0, 2'd0, 16'h0000, 64'h0, 64'h0,                    4'd8 },  // R8 cluster cfg
      '{1'b0, 2'd1, 16'h0010, 64'h0, 64'h800,                  4'd8 },  // R8 revision
      '{1'b0, 2'd0, 16'h0038, 64'h0, 64'h0010_0000,            4'd8 },  // R8 cache cfg
      '{1'b0, 2'd2, 16'h2000, 64'h0, 64'd3,                    4'd7 },  // R7 own window
      '{1'b0, 2'd3, 16'h4000, 64'h0, 64'd3,                    4'd7 },  // R7 remote window
      '{1'b0, 2'd0, 16'h0028, 64'h0, 64'd1,                    4'd11},  // R11 present
      '{1'b0, 2'd0, 16'h0030, 64'h0, 64'd0,                    4'd11},  // R11 absent
      '{1'b1, 2'd0, 16'h0018, 64'h1234_5678_ABCD_FFFF, 64'h0,  4'd9 },
      '{1'b0, 2'd1, 16'h0018, 64'h0, 64'hABCD_8001,            4'd9 },  // R9 masked
      '{1'b1, 2'd0, 16'h0020, 64'h0000_8001, 64'h0,            4'd10},
      '{1'b0, 2'd0, 16'h0020, 64'h0, 64'h0,                    4'd10},  // R10 ignored
      '{1'b1, 2'd1, 16'h2008, 64'd2, 64'h0,                    4'd3 },
      '{1'b0, 2'd1, 16'h2008, 64'h0, 64'd2,                    4'd3 },  // R3 own sel
      '{1'b1, 2'd1, 16'h4010, 64'h8000_1234, 64'h0,            4'd4 },
      '{1'b0, 2'd2, 16'h2010, 64'h0, 64'h8000_1000,            4'd4 },  // R4 remote write
      '{1'b0, 2'd0, 16'h2010, 64'h0, 64'hBFC0_0000,            4'd3 },  // R3 untouched
      '{1'b1, 2'd1, 16'h2008, 64'd4, 64'h0,                    4'd5 },
      '{1'b0, 2'd1, 16'h2008, 64'h0, 64'd2,                    4'd5 },  // R5 at bound
      '{1'b1, 2'd1, 16'h4008, 64'd3, 64'h0,                    4'd4 },
      '{1'b0, 2'd2, 16'h2008, 64'h0, 64'd3,                    4'd4 },  // R4 remote sel
      '{1'b1, 2'd1, 16'h4008, 64'hFF, 64'h0,                   4'd5 },
      '{1'b0, 2'd1, 16'h4008, 64'h0, 64'd3,                    4'd5 },  // R5 far above
      '{1'b1, 2'd0, 16'h0040, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,  4'd13},
      '{1'b0, 2'd0, 16'h0040, 64'h0, 64'h0,                    4'd13},  // R13 offset
      '{1'b1, 2'd0, 16'h0008, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,  4'd12},
      '{1'b0, 2'd3, 16'h0008, 64'h0, 64'h0000_FFFF_FFFF_8000,  4'd12},  // R12 mask
      '{1'b0, 2'd0, 16'h6000, 64'h0, 64'h0,                    4'd13},  // R13 window
      '{1'b1, 2'd0, 16'h4010, 64'h1, 64'h0,                    4'd6 },
      '{1'b0, 2'd0, 16'h2010, 64'h0, 64'h0,                    4'd6 }   // R6 low bits
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_core = '0;
   logic [15:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic        rsp_valid;
   logic [63:0] rsp_rdata;
   logic        ictl_present = 1'b1;
   logic        pwr_present = 1'b0;
   logic [31:0] ictl_base_o;
   logic        ictl_en_o;
   logic [31:0] pwr_base_o;
   logic        pwr_en_o;
   logic [63:0] self_base_sh_o;
   logic [NC*64-1:0] core_vector_o;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   mc_cfg_regs #(.NUM_CORES(NC)) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_write     (req_write),
      .req_core      (req_core),
      .req_addr      (req_addr),
      .req_wdata     (req_wdata),
      .rsp_valid     (rsp_valid),
      .rsp_rdata     (rsp_rdata),
      .ictl_present  (ictl_present),
      .pwr_present   (pwr_present),
      .ictl_base_o   (ictl_base_o),
      .ictl_en_o     (ictl_en_o),
      .pwr_base_o    (pwr_base_o),
      .pwr_en_o      (pwr_en_o),
      .self_base_sh_o(self_base_sh_o),
      .core_vector_o (core_vector_o)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   // drive at a falling edge; the response is registered at the next rising edge
   task automatic access(input logic wr, input logic [1:0] core,
                         input logic [15:0] addr, input logic [63:0] data);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_core  = core;
      req_addr  = addr;
      req_wdata = data;
      @(negedge clk);
      req_valid = 1'b0;
      req_write = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state at the ports
      for (int c = 0; c < NC; c++)
         chk("R1 vector", core_vector_o[c*64 +: 64], 64'hFFFF_FFFF_BFC0_0000);
      chk("R1 ictl base", {31'h0, ictl_en_o, ictl_base_o}, 64'h0);
      chk("R1 pwr base",  {31'h0, pwr_en_o, pwr_base_o}, 64'h0);
      chk("R1 self out", self_base_sh_o, 64'h01FB_F800);
      chk("R2 idle", {63'h0, rsp_valid}, 64'h0);
      for (int c = 0; c < NC; c++) begin
         access(1'b0, 2'(c), 16'h2008, 64'h0);
         chk("R1 selector", rsp_rdata, 64'h0);
         access(1'b0, 2'(c), 16'h2010, 64'h0);
         chk("R1 reset base", rsp_rdata, 64'hBFC0_0000);
      end

      // table walk
      for (int k = 0; k < int'(NV); k++) begin
         access(TBL[k].wr, TBL[k].core, TBL[k].addr, TBL[k].data);
         if (!TBL[k].wr) begin
            chk($sformatf("R%0d vec%0d", TBL[k].req, k), rsp_rdata, TBL[k].exp);
            chk("R2 valid", {63'h0, rsp_valid}, 64'h1);
         end else begin
            chk("R2 no rsp on write", {63'h0, rsp_valid}, 64'h0);
         end
      end

      // R6 vectors after the table: core2 got 0x80001000, core0 got 0
      chk("R6 vec core2", core_vector_o[2*64 +: 64], 64'hFFFF_FFFF_8000_1000);
      chk("R6 vec core0", core_vector_o[0 +: 64], 64'h0);
      chk("R3 vec core1", core_vector_o[1*64 +: 64], 64'hFFFF_FFFF_BFC0_0000);
      // R9 region outputs
      chk("R9 ictl base out", {32'h0, ictl_base_o}, 64'hABCD_8000);
      chk("R9 ictl en out", {63'h0, ictl_en_o}, 64'h1);
      chk("R10 pwr outputs", {31'h0, pwr_en_o, pwr_base_o}, 64'h0);
      // R12 shared copy
      chk("R12 self out", self_base_sh_o, 64'h0000_0FFF_FFFF_F800);

      // R6 positive value: no sign extension ones
      access(1'b1, 2'd3, 16'h2010, 64'hFFFF_FFFF_1234_5FFF);
      chk("R6 vec core3", core_vector_o[3*64 +: 64], 64'h0000_0000_1234_5000);

      // R10 region disappears, then a write is dropped
      ictl_present = 1'b0;
      access(1'b1, 2'd0, 16'h0018, 64'h0);
      chk("R10 ictl kept", {31'h0, ictl_en_o, ictl_base_o}, {31'h0, 1'b1, 32'hABCD_8000});
      access(1'b0, 2'd0, 16'h0028, 64'h0);
      chk("R11 status low", rsp_rdata, 64'h0);
      // R9 presence back: disable via bit 0
      ictl_present = 1'b1;
      pwr_present  = 1'b1;
      access(1'b1, 2'd0, 16'h0018, 64'h0004_0000);
      chk("R9 ictl disabled", {31'h0, ictl_en_o, ictl_base_o}, 64'h0004_0000);
      access(1'b1, 2'd2, 16'h0020, 64'h0000_7FFF);
      chk("R9 pwr low bits", {31'h0, pwr_en_o, pwr_base_o}, {31'h0, 1'b1, 32'h0});
      access(1'b0, 2'd0, 16'h0030, 64'h0);
      chk("R11 status high", rsp_rdata, 64'h1);

      // R13 write to unmapped window changes nothing
      access(1'b1, 2'd0, 16'h6010, 64'h0);
      chk("R13 vec core0 after stray", core_vector_o[0 +: 64], 64'h0);
      access(1'b1, 2'd2, 16'h2048, 64'hFFFF);
      access(1'b0, 2'd2, 16'h2010, 64'h0);
      chk("R13 rb core2 after stray", rsp_rdata, 64'h8000_1000);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule